// File: doc/BRIEF.md
# Sample Container Packer with Tail Padding

This block places one converter sample of configurable resolution, followed by a configurable number of control bits, into a fixed-width container word. The container is either 12 or 16 bits wide. Bit positions that the sample and control bits leave unused fill the low end of the word as information-less padding. That padding is either a constant level or a pseudorandom pattern, and the choice is made by configuration. The pseudorandom option keeps a repeating padding value from producing spurious tones.

A companion unpacking path on the receive side takes container words and returns the sample and control bits. It discards the padding using only the shared configuration settings. Both paths have one registered stage, and each passes its valid qualifier through unchanged. A configuration whose sample and control bits cannot fit the selected container raises a configuration-error flag.

Top module: `sample_container_codec`

## Requirements
- R1: While reset is asserted, and afterwards until the first valid input, outValid, outWord, rxOutValid, rxSample and rxCtrl are all zero.
- R2: outValid equals inValid one clock earlier. A word accepted with inValid appears on outWord after exactly one rising edge.
- R3: The packed layout, with C the container width (16 when cfgWide=1, otherwise 12), places the low cfgRes bits of inSample in bits C-1 down to C-cfgRes. The low cfgCtrl bits of inCtrl come directly below the sample. The remaining T = C-cfgRes-cfgCtrl low bits are tail. In a 12-bit container, outWord[15:12] are zero.
- R4: With cfgTailPrbs=0, every tail bit equals cfgTailLevel.
- R5: With cfgTailPrbs=1, the tail is the low T bits of the 16-bit pattern {s[6:0], s[8:0]}, where s is a 9-bit generator state. The state resets to 9'h1FF and steps to {s[7:0], s[8]^s[4]} (polynomial x^9+x^5+1). It steps once per word accepted with inValid, and a word uses the state held before its own step. Idle cycles do not step the state.
- R6: rxOutValid equals rxValid one clock earlier. rxSample returns the cfgRes-bit sample field of rxWord right-aligned, with the upper bits zero. rxCtrl returns the cfgCtrl-bit control field right-aligned, using the layout of R3.
- R7: The unpacker output does not depend on the tail bits of rxWord, or on rxWord[15:12] in a 12-bit container.
- R8: cfgErr is high, combinationally, exactly when cfgRes=0 or cfgRes+cfgCtrl exceeds C. A word accepted while cfgErr is high packs to zero, and an unpacked result taken while it is high is zero.
- R9: outWord holds its value in cycles after inValid is low. rxSample and rxCtrl hold their values in cycles after rxValid is low.
- R10: With C=16, cfgRes=13 and cfgCtrl=0, the tail is 3 bits wide. For example, sample 13'h1ABC with cfgTailLevel=1 packs to 16'hD5E7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgRes | input | 5 | Sample resolution in bits (1 to 16) |
| cfgCtrl | input | 2 | Control bits per sample (0 to 3) |
| cfgWide | input | 1 | Container width: 1 selects 16 bits, 0 selects 12 bits |
| cfgTailPrbs | input | 1 | Tail source: 1 selects pseudorandom, 0 selects constant |
| cfgTailLevel | input | 1 | Constant tail level |
| cfgErr | output | 1 | Configuration does not fit the container |
| inValid | input | 1 | Sample qualifier |
| inSample | input | 16 | Sample, right-aligned |
| inCtrl | input | 3 | Control bits, right-aligned |
| outValid | output | 1 | Packed word qualifier |
| outWord | output | 16 | Packed container word, right-aligned |
| rxValid | input | 1 | Received word qualifier |
| rxWord | input | 16 | Received container word, right-aligned |
| rxOutValid | output | 1 | Unpacked result qualifier |
| rxSample | output | 16 | Recovered sample, right-aligned |
| rxCtrl | output | 3 | Recovered control bits, right-aligned |

## Verification
Packed and unpacked results are due on the first rising edge after their inputs are driven. cfgErr is combinational and is due within the same cycle. The driver records the cycle number with each expected item. The monitor samples on the falling edge and requires each result to arrive exactly one cycle after its stimulus, so a result that comes early or late fails. In idle cycles the monitor checks that both output registers keep their previous values. The bench also carries its own copy of the generator state, stepped only for accepted words, so pseudorandom tails are checked across idle gaps.

// File: rtl/scp_pkg.sv
package scp_pkg;
  localparam int MAX_W    = 16;
  localparam int NARROW_W = 12;
  localparam int CTRL_W   = 3;
  localparam int CS_W     = 2;
  localparam int RES_W    = 5;
  localparam int CNT_W    = 5;
  localparam int LFSR_W   = 9;
  localparam logic [LFSR_W-1:0] LFSR_SEED = '1;

  typedef struct packed {
    logic packLoad;
    logic rxLoad;
    logic lfsrStep;
    logic cfgBad;
  } strobe_t;

  typedef struct packed {
    logic [RES_W-1:0] resBits;
    logic [CS_W-1:0]  ctrlBits;
    logic [CNT_W-1:0] tailBits;
    logic [CNT_W-1:0] ctrlPos;
    logic [CNT_W-1:0] samplePos;
  } layout_t;

  function automatic logic [MAX_W-1:0] lowMask(input logic [CNT_W-1:0] n);
    return ~({MAX_W{1'b1}} << n);
  endfunction
endpackage

// File: rtl/scp_ctrl.sv
module scp_ctrl
  import scp_pkg::*;
#(
  parameter int WIDE_W = MAX_W,
  parameter int SLIM_W = NARROW_W
) (
  input  logic [RES_W-1:0] cfgRes,
  input  logic [CS_W-1:0]  cfgCtrl,
  input  logic             cfgWide,
  input  logic             inValid,
  input  logic             rxValid,
  output strobe_t          stb,
  output layout_t          lay
);
  localparam int SUM_W = CNT_W + 1;

  logic [SUM_W-1:0] containerBits;
  logic [SUM_W-1:0] usedBits;
  logic             tooWide;
  logic             noSample;
  logic [CNT_W-1:0] tailCount;

  always_comb begin
    containerBits = cfgWide ? SUM_W'(WIDE_W) : SUM_W'(SLIM_W);
    usedBits      = SUM_W'(cfgRes) + SUM_W'(cfgCtrl);
    tooWide       = usedBits > containerBits;
    noSample      = (cfgRes == '0);
    tailCount     = (tooWide || noSample) ? '0 : CNT_W'(containerBits - usedBits);
  end

  always_comb begin
    stb.packLoad  = inValid;
    stb.rxLoad    = rxValid;
    stb.lfsrStep  = inValid;
    stb.cfgBad    = tooWide || noSample;
    lay.resBits   = cfgRes;
    lay.ctrlBits  = cfgCtrl;
    lay.tailBits  = tailCount;
    lay.ctrlPos   = tailCount;
    lay.samplePos = tailCount + CNT_W'(cfgCtrl);
  end
endmodule

// File: rtl/scp_datapath.sv
module scp_datapath
  import scp_pkg::*;
#(
  parameter int DATA_W = MAX_W,
  parameter int CS_MAX = CTRL_W,
  parameter int GEN_W  = LFSR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  layout_t           lay,
  input  logic              cfgTailPrbs,
  input  logic              cfgTailLevel,
  input  logic [DATA_W-1:0] inSample,
  input  logic [CS_MAX-1:0] inCtrl,
  input  logic [DATA_W-1:0] rxWord,
  output logic              outValid,
  output logic [DATA_W-1:0] outWord,
  output logic              rxOutValid,
  output logic [DATA_W-1:0] rxSample,
  output logic [CS_MAX-1:0] rxCtrl
);
  logic [GEN_W-1:0]  lfsrQ;
  logic [DATA_W-1:0] prbsFill;
  logic [DATA_W-1:0] tailFill;
  logic [DATA_W-1:0] sampleField;
  logic [DATA_W-1:0] ctrlField;
  logic [DATA_W-1:0] packNext;
  logic [DATA_W-1:0] rxShiftS;
  logic [DATA_W-1:0] rxShiftC;
  logic [DATA_W-1:0] ctrlMask;
  logic [DATA_W-1:0] rxSampleNext;
  logic [CS_MAX-1:0] rxCtrlNext;

  // The generator state is repeated across the word so any tail length has a source bit.
  for (genvar gi = 0; gi < DATA_W; gi++) begin : g_fill
    assign prbsFill[gi] = lfsrQ[gi % GEN_W];
  end

  always_comb begin
    tailFill    = cfgTailPrbs ? prbsFill : {DATA_W{cfgTailLevel}};
    ctrlMask    = lowMask(CNT_W'(lay.ctrlBits));
    sampleField = (inSample & lowMask(lay.resBits)) << lay.samplePos;
    ctrlField   = ({{(DATA_W-CS_MAX){1'b0}}, inCtrl} & ctrlMask) << lay.ctrlPos;
    packNext    = stb.cfgBad ? '0
                : (sampleField | ctrlField | (tailFill & lowMask(lay.tailBits)));
  end

  always_comb begin
    rxShiftS     = rxWord >> lay.samplePos;
    rxShiftC     = (rxWord >> lay.ctrlPos) & ctrlMask;
    rxSampleNext = stb.cfgBad ? '0 : (rxShiftS & lowMask(lay.resBits));
    rxCtrlNext   = stb.cfgBad ? '0 : rxShiftC[CS_MAX-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lfsrQ <= LFSR_SEED;
    end else if (stb.lfsrStep) begin
      lfsrQ <= {lfsrQ[GEN_W-2:0], lfsrQ[GEN_W-1] ^ lfsrQ[4]};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outWord  <= '0;
    end else begin
      outValid <= stb.packLoad;
      if (stb.packLoad) outWord <= packNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxOutValid <= 1'b0;
      rxSample   <= '0;
      rxCtrl     <= '0;
    end else begin
      rxOutValid <= stb.rxLoad;
      if (stb.rxLoad) begin
        rxSample <= rxSampleNext;
        rxCtrl   <= rxCtrlNext;
      end
    end
  end
endmodule

// File: rtl/sample_container_codec.sv
module sample_container_codec
  import scp_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [RES_W-1:0]   cfgRes,
  input  logic [CS_W-1:0]    cfgCtrl,
  input  logic               cfgWide,
  input  logic               cfgTailPrbs,
  input  logic               cfgTailLevel,
  output logic               cfgErr,
  input  logic               inValid,
  input  logic [MAX_W-1:0]   inSample,
  input  logic [CTRL_W-1:0]  inCtrl,
  output logic               outValid,
  output logic [MAX_W-1:0]   outWord,
  input  logic               rxValid,
  input  logic [MAX_W-1:0]   rxWord,
  output logic               rxOutValid,
  output logic [MAX_W-1:0]   rxSample,
  output logic [CTRL_W-1:0]  rxCtrl
);
  strobe_t stb;
  layout_t lay;

  scp_ctrl #(.WIDE_W(MAX_W), .SLIM_W(NARROW_W)) u_ctrl (
    .cfgRes  (cfgRes),
    .cfgCtrl (cfgCtrl),
    .cfgWide (cfgWide),
    .inValid (inValid),
    .rxValid (rxValid),
    .stb     (stb),
    .lay     (lay)
  );

  scp_datapath #(.DATA_W(MAX_W), .CS_MAX(CTRL_W), .GEN_W(LFSR_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .stb          (stb),
    .lay          (lay),
    .cfgTailPrbs  (cfgTailPrbs),
    .cfgTailLevel (cfgTailLevel),
    .inSample     (inSample),
    .inCtrl       (inCtrl),
    .rxWord       (rxWord),
    .outValid     (outValid),
    .outWord      (outWord),
    .rxOutValid   (rxOutValid),
    .rxSample     (rxSample),
    .rxCtrl       (rxCtrl)
  );

  assign cfgErr = stb.cfgBad;
endmodule

// File: rtl/scp_checker.sv
module scp_checker
  import scp_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              cfgWide,
  input logic              cfgErr,
  input logic              inValid,
  input logic              outValid,
  input logic [MAX_W-1:0]  outWord,
  input logic              rxValid,
  input logic              rxOutValid,
  input logic [MAX_W-1:0]  rxSample,
  input logic [CTRL_W-1:0] rxCtrl
);
  p_valid_delay_r2: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  p_idle_delay_r2: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
  p_rx_delay_r6: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> rxOutValid);
  p_rx_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    !rxValid |=> !rxOutValid);
  p_word_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(outWord));
  p_rx_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !rxValid |=> ($stable(rxSample) && $stable(rxCtrl)));
  p_err_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && cfgErr) |=> (outWord == '0));
  p_rx_err_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && cfgErr) |=> (rxSample == '0 && rxCtrl == '0));
  p_narrow_top_r3: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !cfgWide) |=> (outWord[MAX_W-1:NARROW_W] == '0));
endmodule

bind sample_container_codec scp_checker u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .cfgWide    (cfgWide),
  .cfgErr     (cfgErr),
  .inValid    (inValid),
  .outValid   (outValid),
  .outWord    (outWord),
  .rxValid    (rxValid),
  .rxOutValid (rxOutValid),
  .rxSample   (rxSample),
  .rxCtrl     (rxCtrl)
);

// File: tb/sample_container_codec_test.sv
`timescale 1ns/1ps
module sample_container_codec_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  cfgRes = 5'd13;
  logic [1:0]  cfgCtrl = 2'd0;
  logic        cfgWide = 1'b1;
  logic        cfgTailPrbs = 1'b0;
  logic        cfgTailLevel = 1'b0;
  logic        cfgErr;
  logic        inValid = 1'b0;
  logic [15:0] inSample = '0;
  logic [2:0]  inCtrl = '0;
  logic        outValid;
  logic [15:0] outWord;
  logic        rxValid = 1'b0;
  logic [15:0] rxWord = '0;
  logic        rxOutValid;
  logic [15:0] rxSample;
  logic [2:0]  rxCtrl;

  sample_container_codec uut (.*);

  always #2.5 clk = ~clk;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 0;
  logic [8:0] genState = 9'h1FF;

  logic [15:0] expWord[$];
  int          expWordCyc[$];
  string       expWordTag[$];
  logic [15:0] expS[$];
  logic [2:0]  expC[$];
  int          expRxCyc[$];
  string       expRxTag[$];
  logic [15:0] lastWord = '0;
  logic [15:0] lastS = '0;
  logic [2:0]  lastC = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic int mk(input int k);
    return (1 << k) - 1;
  endfunction

  function automatic bit refErr(input int n, input int cs, input bit wide);
    int nb = wide ? 16 : 12;
    return (n == 0) || (n + cs > nb);
  endfunction

  function automatic logic [15:0] refPack(input int s, input int c, input logic [8:0] st);
    int nb = cfgWide ? 16 : 12;
    int n = cfgRes;
    int cs = cfgCtrl;
    int t, w, pat;
    if (refErr(n, cs, cfgWide)) return 16'h0;
    t = nb - n - cs;
    pat = cfgTailPrbs ? {16'h0, st[6:0], st[8:0]} : (cfgTailLevel ? 32'hFFFF : 0);
    w = ((s & mk(n)) << (cs + t)) | ((c & mk(cs)) << t) | (pat & mk(t));
    return w[15:0];
  endfunction

  task automatic setCfg(input int n, input int cs, input bit wide, input bit prbs, input bit lvl);
    cfgRes = 5'(n); cfgCtrl = 2'(cs); cfgWide = wide; cfgTailPrbs = prbs; cfgTailLevel = lvl;
  endtask

  task automatic packOne(input logic [15:0] s, input logic [2:0] c, input string tag);
    inValid = 1'b1; inSample = s; inCtrl = c;
    expWord.push_back(refPack(s, c, genState));
    expWordCyc.push_back(cyc);
    expWordTag.push_back(tag);
    genState = {genState[7:0], genState[8] ^ genState[4]};
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic rxOne(input logic [15:0] w, input string tag);
    int nb = cfgWide ? 16 : 12;
    int n = cfgRes;
    int cs = cfgCtrl;
    int t, sv, cv;
    rxValid = 1'b1; rxWord = w;
    if (refErr(n, cs, cfgWide)) begin
      sv = 0; cv = 0;
    end else begin
      t = nb - n - cs;
      sv = (int'(w) >> (cs + t)) & mk(n);
      cv = (int'(w) >> t) & mk(cs);
    end
    expS.push_back(sv[15:0]);
    expC.push_back(cv[2:0]);
    expRxCyc.push_back(cyc);
    expRxTag.push_back(tag);
    @(negedge clk);
    rxValid = 1'b0;
  endtask

  task automatic idle(input int k);
    repeat (k) @(negedge clk);
  endtask

  // Packer monitor: result due one rising edge after the driving cycle (R2)
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (outValid) begin
        if (expWord.size() == 0) begin
          chk("R2 unexpected outValid", 1, 0);
        end else begin
          chk({expWordTag[0], " word"}, outWord, expWord[0]);
          chk("R2 latency", cyc, expWordCyc[0] + 1);
          void'(expWord.pop_front()); void'(expWordCyc.pop_front()); void'(expWordTag.pop_front());
        end
      end else begin
        chk("R9 outWord hold", outWord, lastWord);
        if (expWord.size() != 0 && expWordCyc[0] + 1 < cyc) chk("R2 overdue", 0, 1);
      end
      lastWord = outWord;
    end
  end

  // Unpacker monitor (R6, R9)
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (rxOutValid) begin
        if (expS.size() == 0) begin
          chk("R6 unexpected rxOutValid", 1, 0);
        end else begin
          chk({expRxTag[0], " sample"}, rxSample, expS[0]);
          chk({expRxTag[0], " ctrl"}, rxCtrl, expC[0]);
          chk("R6 latency", cyc, expRxCyc[0] + 1);
          void'(expS.pop_front()); void'(expC.pop_front());
          void'(expRxCyc.pop_front()); void'(expRxTag.pop_front());
        end
      end else begin
        chk("R9 rx hold", {rxCtrl, rxSample}, {lastC, lastS});
        if (expS.size() != 0 && expRxCyc[0] + 1 < cyc) chk("R6 overdue", 0, 1);
      end
      lastS = rxSample;
      lastC = rxCtrl;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset outValid", outValid, 0);
    chk("R1 reset outWord", outWord, 0);
    chk("R1 reset rx", {rxOutValid, rxCtrl, rxSample}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 after release", {outValid, outWord, rxOutValid, rxCtrl, rxSample}, 0);

    // R10 reference case, constant tail of ones (R4)
    setCfg(13, 0, 1, 0, 1);
    #1 chk("R8 legal reference cfg", cfgErr, 0);
    packOne(16'h1ABC, 3'd0, "R10 ref");
    chk("R10 literal", outWord, 16'hD5E7);
    rxOne(16'hD5E7, "R10 rx");
    chk("R10 rx literal", rxSample, 16'h1ABC);
    setCfg(13, 0, 1, 0, 0);
    packOne(16'hFFFF, 3'd7, "R4 tail zero");
    packOne(16'h0001, 3'd0, "R4 tail zero");
    idle(2);

    // R3 narrow container with control bits
    setCfg(10, 2, 0, 0, 1);
    packOne(16'h02A5, 3'd2, "R3 narrow");
    packOne(16'hFFFF, 3'd7, "R3 narrow masked");
    packOne(16'h0000, 3'd1, "R3 narrow");
    rxOne(16'hF9AB, "R7 narrow top ignored");
    rxOne(16'h09AB, "R7 narrow top ignored");
    idle(1);

    // R5 pseudorandom tails across idle gaps
    setCfg(8, 3, 1, 1, 0);
    for (int i = 0; i < 12; i++) begin
      packOne(16'(i * 37 + 5), 3'(i), "R5 prbs wide");
      if (i % 4 == 3) idle(3);
    end
    setCfg(5, 1, 0, 1, 0);
    for (int i = 0; i < 8; i++) packOne(16'(i * 11), 3'(i), "R5 prbs narrow");
    idle(2);

    // R6/R7 unpack with varied tails
    setCfg(9, 2, 1, 0, 0);
    rxOne({9'h15A, 2'd3, 5'h00}, "R7 tail zero");
    rxOne({9'h15A, 2'd3, 5'h1F}, "R7 tail ones");
    rxOne({9'h0C3, 2'd1, 5'h0A}, "R6 unpack");
    setCfg(16, 0, 1, 0, 0);
    #1 chk("R8 full width legal", cfgErr, 0);
    packOne(16'hBEEF, 3'd5, "R3 full width");
    rxOne(16'hCAFE, "R6 full width");
    setCfg(12, 0, 0, 1, 0);
    #1 chk("R8 narrow full legal", cfgErr, 0);
    packOne(16'hFABC, 3'd0, "R3 narrow full");
    idle(1);

    // R8 illegal configurations
    setCfg(14, 3, 1, 0, 1);
    #1 chk("R8 overflow wide", cfgErr, 1);
    packOne(16'h1234, 3'd7, "R8 err pack");
    rxOne(16'hFFFF, "R8 err unpack");
    setCfg(0, 0, 1, 0, 1);
    #1 chk("R8 zero resolution", cfgErr, 1);
    packOne(16'hFFFF, 3'd0, "R8 err pack zero res");
    setCfg(11, 2, 0, 0, 1);
    #1 chk("R8 overflow narrow", cfgErr, 1);
    setCfg(11, 1, 0, 1, 1);
    #1 chk("R8 exact narrow fit", cfgErr, 0);
    packOne(16'h0555, 3'd1, "R5 prbs zero tail");
    idle(4);

    chk("queues drained", expWord.size() + expS.size(), 0);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule